// File: doc/BRIEF.md
# Signature-Screened Droop Predictor Table

This block decides, at every update of the core's event history, whether the current execution context has led to a supply-voltage emergency before. A lookup presents a 128-bit signature, which is a 32-bit anchor PC followed by 96 bits of event history. A throttle request goes out only when two tests both pass. The anchor PC must sit in a fully associative tag store, and the three bits that the signature selects in a bit-vector membership filter must all be set. Because the tag store screens the filter, a filter false positive only throttles when its anchor PC is a known offender.

Training comes from the recovery path. After a detected emergency, the anchor PC and history that were current at that moment are presented on the insert port. A small recurrence table counts emergencies per anchor PC. A signature is promoted into the tag store and the filter only once the same anchor PC has recurred often enough. A throttle request opens a window of `HOLD` cycles. Inside that window the core is stalled on every other cycle. Filter bits are cleared only by reset.

Top module: `emerg_predictor`

## Requirements
- R1: `thr_req` is high for exactly the cycle after a clock edge at which `lk_valid` was high, `lk_pc` was resident in the tag store and all three filter bits of `{lk_pc, lk_hist}` were set. In every other cycle it is low.
- R2: Filter index k (k = 0, 1, 2) is the XOR of all 10-bit slices of the 128-bit signature `{pc, hist}` after a left rotation by 11*k bits. The top partial slice is zero-extended.
- R3: A lookup whose anchor PC is not resident never requests throttling, even when its filter bits are set.
- R4: With threshold T = 1, the first emergency on an anchor PC promotes nothing. Each emergency on a PC already in the 4-slot recurrence table raises that slot's count. When the count already equals T, the emergency promotes instead and frees the slot. A PC that is absent takes the slot at the recurrence table's round-robin pointer, with count 1, and the pointer advances.
- R5: A promotion sets the three filter bits of `{em_pc, em_hist}` and writes `em_pc` into the tag store, unless it is already resident.
- R6: The 128-entry tag store fills and replaces in round-robin order. A PC that is already resident is not written again and does not move the pointer.
- R7: `thr_active` is high for exactly `HOLD` (6) cycles, starting in the cycle where `thr_req` is high. A new request inside the window restarts it at full length.
- R8: `core_stall` is high in the first cycle of the window and alternates every cycle after that while `thr_active` is high. It is low outside the window.
- R9: A lookup and an insert in the same cycle both take effect. The lookup is judged against the state before that insert.
- R10: After reset all outputs are low and the tag store, filter and recurrence table are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request, issued on each history update |
| lk_pc | input | 32 | Anchor PC of the lookup signature |
| lk_hist | input | 96 | Event history of the lookup signature |
| em_valid | input | 1 | Emergency insert request |
| em_pc | input | 32 | Anchor PC current at the emergency |
| em_hist | input | 96 | Event history current at the emergency |
| thr_req | output | 1 | One-cycle throttle request |
| thr_active | output | 1 | Throttle window in progress |
| core_stall | output | 1 | Stall the core this cycle |

## Verification
The two functions that can fall in the same cycle are a lookup and an insert. The sharpest case is a lookup of the very signature whose recurring emergency is promoting it in that cycle. The bench drives that collision directly: it expects no request in the collision cycle and a request on the following lookup. Random traffic over a small pool of PCs and histories makes collisions frequent. A reference model that applies every lookup before every insert judges each cycle's outputs.

// File: rtl/emp_pkg.sv
package emp_pkg;
  localparam int NUM_HASH = 3;
  localparam int ROT_STEP = 11;

  typedef enum logic [1:0] {
    PEND_IDLE,
    PEND_ALLOC,
    PEND_COUNT,
    PEND_PROMOTE
  } pend_act_e;
endpackage

// File: rtl/emp_hash.sv
module emp_hash #(
  parameter int SIG_W = 128,
  parameter int IDX_W = 10,
  parameter int ROT   = 0
) (
  input  logic [SIG_W-1:0] sig,
  output logic [IDX_W-1:0] idx
);
  localparam int R     = ROT % SIG_W;
  localparam int NCH   = (SIG_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = NCH * IDX_W;

  logic [SIG_W-1:0] rot;
  logic [PAD_W-1:0] padded;

  generate
    if (R == 0) begin : g_norot
      assign rot = sig;
    end else begin : g_rot
      assign rot = {sig[SIG_W-R-1:0], sig[SIG_W-1:SIG_W-R]};
    end
  endgenerate

  assign padded = PAD_W'(rot);

  always_comb begin
    idx = '0;
    for (int c = 0; c < NCH; c++) idx = idx ^ padded[c*IDX_W +: IDX_W];
  end
endmodule

// File: rtl/emp_cam.sv
module emp_cam #(
  parameter int DEPTH = 128,
  parameter int PC_W  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] q_pc,
  output logic            q_hit,
  input  logic            w_en,
  input  logic [PC_W-1:0] w_pc,
  output logic            w_hit
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PC_W-1:0]  tag_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             do_wr;

  always_comb begin
    q_hit = 1'b0;
    w_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && tag_q[i] == q_pc) q_hit = 1'b1;
      if (vld_q[i] && tag_q[i] == w_pc) w_hit = 1'b1;
    end
  end

  assign do_wr = w_en & ~w_hit;

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (do_wr) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) tag_q[ptr_q] <= w_pc;
  end
endmodule

// File: rtl/emp_pending.sv
module emp_pending
  import emp_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int PC_W   = 32,
  parameter int THRESH = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            em_valid,
  input  logic [PC_W-1:0] em_pc,
  output logic            promote
);
  generate
    if (THRESH == 0) begin : g_direct
      assign promote = em_valid;
    end else begin : g_table
      localparam int PTR_W = $clog2(DEPTH);
      localparam int CNT_W = $clog2(THRESH + 1) + 1;

      logic [PC_W-1:0]  pc_q  [DEPTH];
      logic [CNT_W-1:0] cnt_q [DEPTH];
      logic [DEPTH-1:0] vld_q, vld_d;
      logic [PTR_W-1:0] rr_q, rr_d, hidx;
      logic             hit;
      pend_act_e        act;

      always_comb begin
        hit  = 1'b0;
        hidx = '0;
        for (int i = 0; i < DEPTH; i++) begin
          if (vld_q[i] && pc_q[i] == em_pc) begin
            hit  = 1'b1;
            hidx = PTR_W'(i);
          end
        end
      end

      always_comb begin
        if (!em_valid)                            act = PEND_IDLE;
        else if (!hit)                            act = PEND_ALLOC;
        else if (cnt_q[hidx] == CNT_W'(THRESH))   act = PEND_PROMOTE;
        else                                      act = PEND_COUNT;
      end

      assign promote = (act == PEND_PROMOTE);

      always_comb begin
        vld_d = vld_q;
        rr_d  = rr_q;
        if (act == PEND_ALLOC) begin
          vld_d[rr_q] = 1'b1;
          rr_d = (rr_q == PTR_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
        end else if (act == PEND_PROMOTE) begin
          vld_d[hidx] = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= '0;
          rr_q  <= '0;
        end else begin
          vld_q <= vld_d;
          rr_q  <= rr_d;
        end
      end

      always_ff @(posedge clk) begin
        if (act == PEND_ALLOC) begin
          pc_q[rr_q]  <= em_pc;
          cnt_q[rr_q] <= CNT_W'(1);
        end else if (act == PEND_COUNT) begin
          cnt_q[hidx] <= cnt_q[hidx] + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/emp_throttle.sv
module emp_throttle #(
  parameter int HOLD = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active,
  output logic stall
);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (fire) begin
      cnt_d   = CNT_W'(HOLD);
      phase_d = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d   = cnt_q - 1'b1;
      phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign active = (cnt_q != '0);
  assign stall  = active & phase_q;
endmodule

// File: rtl/emerg_predictor.sv
module emerg_predictor
  import emp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int HIST_W     = 96,
  parameter int IDX_W      = 10,
  parameter int CAM_DEPTH  = 128,
  parameter int PEND_DEPTH = 4,
  parameter int THRESH     = 1,
  parameter int HOLD       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [HIST_W-1:0] lk_hist,
  input  logic              em_valid,
  input  logic [PC_W-1:0]   em_pc,
  input  logic [HIST_W-1:0] em_hist,
  output logic              thr_req,
  output logic              thr_active,
  output logic              core_stall
);
  localparam int SIG_W = PC_W + HIST_W;
  localparam int BITS  = 1 << IDX_W;

  logic [1:0]       rsync_q;
  logic             rst_i;
  logic [SIG_W-1:0] lk_sig, em_sig;
  logic [IDX_W-1:0] lk_idx [NUM_HASH];
  logic [IDX_W-1:0] em_idx [NUM_HASH];
  logic [BITS-1:0]  bloom_q, bloom_d;
  logic             bloom_all, cam_q_hit, cam_w_hit, promote, fire, req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  assign lk_sig = {lk_pc, lk_hist};
  assign em_sig = {em_pc, em_hist};

  generate
    for (genvar h = 0; h < NUM_HASH; h++) begin : g_hash
      emp_hash #(.SIG_W(SIG_W), .IDX_W(IDX_W), .ROT(h * ROT_STEP)) u_lk (
        .sig(lk_sig), .idx(lk_idx[h]));
      emp_hash #(.SIG_W(SIG_W), .IDX_W(IDX_W), .ROT(h * ROT_STEP)) u_em (
        .sig(em_sig), .idx(em_idx[h]));
    end
  endgenerate

  emp_cam #(.DEPTH(CAM_DEPTH), .PC_W(PC_W)) u_cam (
    .clk(clk), .rst_n(rst_i), .q_pc(lk_pc), .q_hit(cam_q_hit),
    .w_en(promote), .w_pc(em_pc), .w_hit(cam_w_hit));

  emp_pending #(.DEPTH(PEND_DEPTH), .PC_W(PC_W), .THRESH(THRESH)) u_pend (
    .clk(clk), .rst_n(rst_i), .em_valid(em_valid), .em_pc(em_pc),
    .promote(promote));

  always_comb begin
    bloom_all = 1'b1;
    bloom_d   = bloom_q;
    for (int h = 0; h < NUM_HASH; h++) begin
      bloom_all = bloom_all & bloom_q[lk_idx[h]];
      if (promote) bloom_d[em_idx[h]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) bloom_q <= '0;
    else        bloom_q <= bloom_d;
  end

  assign fire = lk_valid & cam_q_hit & bloom_all;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) req_q <= 1'b0;
    else        req_q <= fire;
  end
  assign thr_req = req_q;

  emp_throttle #(.HOLD(HOLD)) u_thr (
    .clk(clk), .rst_n(rst_i), .fire(fire), .active(thr_active),
    .stall(core_stall));
endmodule

// File: rtl/emp_checker.sv
module emp_checker (
  input logic clk,
  input logic rst_n,
  input logic lk_valid,
  input logic cam_hit,
  input logic thr_req,
  input logic thr_active,
  input logic core_stall
);
  AST_REQ_NEEDS_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
    thr_req |-> $past(lk_valid && cam_hit)); // R3

  AST_REQ_OPENS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    thr_req |-> (thr_active && core_stall)); // R8

  AST_STALL_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> thr_active); // R8

  AST_STALL_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_active && $past(thr_active) && !thr_req) |-> (core_stall != $past(core_stall))); // R8

  AST_WINDOW_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_active && !thr_req) |=> (!thr_active || thr_req)); // R7

  AST_REQ_SINGLE_CYCLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_req && !$past(lk_valid)) |-> 1'b0); // R1
endmodule

bind emerg_predictor emp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .cam_hit(cam_q_hit),
  .thr_req(thr_req), .thr_active(thr_active), .core_stall(core_stall));

// File: tb/tb_emerg_predictor.sv
module tb_emerg_predictor;
  localparam int HOLD = 6;
  localparam int CAMD = 128;
  localparam int PEND = 4;

  logic        clk, rst_n;
  logic        lk_valid, em_valid;
  logic [31:0] lk_pc, em_pc;
  logic [95:0] lk_hist, em_hist;
  logic        thr_req, thr_active, core_stall;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  emerg_predictor dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .lk_hist(lk_hist), .em_valid(em_valid), .em_pc(em_pc), .em_hist(em_hist),
    .thr_req(thr_req), .thr_active(thr_active), .core_stall(core_stall));

  initial clk = 0;
  always #2 clk = ~clk;

  // reference model state
  logic [31:0] m_cam_pc [CAMD];
  bit          m_cam_v  [CAMD];
  int          m_cam_ptr;
  bit          m_bloom  [1024];
  logic [31:0] m_pd_pc  [PEND];
  bit          m_pd_v   [PEND];
  int          m_pd_cnt [PEND];
  int          m_pd_rr;
  int          m_cnt;
  bit          m_phase, m_req;

  function automatic logic [9:0] bhash(logic [127:0] s, int k);
    logic [9:0] r = '0;
    for (int p = 0; p < 128; p++) r[p % 10] ^= s[((p - 11 * k) % 128 + 128) % 128];
    return r;
  endfunction

  function automatic bit m_has(logic [31:0] pc);
    for (int i = 0; i < CAMD; i++) if (m_cam_v[i] && m_cam_pc[i] == pc) return 1;
    return 0;
  endfunction

  function automatic bit m_bits(logic [127:0] s);
    return m_bloom[bhash(s, 0)] && m_bloom[bhash(s, 1)] && m_bloom[bhash(s, 2)];
  endfunction

  task automatic model_edge();
    bit fire, prom;
    int hi;
    fire = lk_valid && m_has(lk_pc) && m_bits({lk_pc, lk_hist});
    prom = 0;
    if (em_valid) begin
      hi = -1;
      for (int i = 0; i < PEND; i++) if (m_pd_v[i] && m_pd_pc[i] == em_pc) hi = i;
      if (hi < 0) begin
        m_pd_v[m_pd_rr] = 1; m_pd_pc[m_pd_rr] = em_pc; m_pd_cnt[m_pd_rr] = 1;
        m_pd_rr = (m_pd_rr + 1) % PEND;
      end else if (m_pd_cnt[hi] == 1) begin
        prom = 1; m_pd_v[hi] = 0;
      end else m_pd_cnt[hi]++;
    end
    if (prom) begin
      if (!m_has(em_pc)) begin
        m_cam_pc[m_cam_ptr] = em_pc; m_cam_v[m_cam_ptr] = 1;
        m_cam_ptr = (m_cam_ptr + 1) % CAMD;
      end
      for (int k = 0; k < 3; k++) m_bloom[bhash({em_pc, em_hist}, k)] = 1;
    end
    if (fire) begin m_cnt = HOLD; m_phase = 1; end
    else if (m_cnt > 0) begin m_cnt--; m_phase = ~m_phase; end
    m_req = fire;
  endtask

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "thr_req", thr_req, m_req);
    chk("R7", "thr_active", thr_active, m_cnt > 0);
    chk("R8", "core_stall", core_stall, (m_cnt > 0) && m_phase);
  endtask

  task automatic cyc(bit lv, logic [31:0] lp, logic [95:0] lh,
                     bit ev, logic [31:0] ep, logic [95:0] eh, string tag);
    lk_valid = lv; lk_pc = lp; lk_hist = lh;
    em_valid = ev; em_pc = ep; em_hist = eh;
    step(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, '0, '0, tag);
  endtask

  task automatic insert2(logic [31:0] pc, logic [95:0] h);
    cyc(0, '0, '0, 1, pc, h, "R4");
    cyc(0, '0, '0, 1, pc, h, "R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [95:0] hA, hB, hX, pool_h [4];
    logic [31:0] pA, pB;
    void'($urandom(32'd9137));
    for (int i = 0; i < CAMD; i++) m_cam_v[i] = 0;
    for (int i = 0; i < 1024; i++) m_bloom[i] = 0;
    for (int i = 0; i < PEND; i++) m_pd_v[i] = 0;
    m_cam_ptr = 0; m_pd_rr = 0; m_cnt = 0; m_phase = 0; m_req = 0;
    lk_valid = 0; em_valid = 0; lk_pc = 0; em_pc = 0; lk_hist = 0; em_hist = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "thr_req", thr_req, 0);
    chk("R10", "thr_active", thr_active, 0);
    chk("R10", "core_stall", core_stall, 0);

    pA = 32'h0040_1000; pB = 32'h0040_2000;
    hA = {$urandom, $urandom, $urandom};
    hB = {$urandom, $urandom, $urandom};
    hX = {$urandom, $urandom, $urandom};
    cyc(1, pA, hA, 0, '0, '0, "R10");           // empty tables: no request

    // R4: one emergency promotes nothing, second one does
    cyc(0, '0, '0, 1, pA, hA, "R4");
    cyc(1, pA, hA, 0, '0, '0, "R4");
    cyc(0, '0, '0, 1, pA, hA, "R5");
    cyc(1, pA, hA, 0, '0, '0, "R5");            // request expected
    idle(3, "R8");
    cyc(1, pA, hA, 0, '0, '0, "R7");            // retrigger inside window
    idle(8, "R7");
    cyc(1, pA, hX, 0, '0, '0, "R2");            // same PC, other history

    // R9: collision of promoting insert with lookup of same signature
    cyc(0, '0, '0, 1, pB, hB, "R9");
    cyc(1, pB, hB, 1, pB, hB, "R9");            // no request: pre-insert state
    cyc(1, pB, hB, 0, '0, '0, "R9");            // now it requests
    idle(7, "R7");

    // R4: recurrence slot lost to round-robin reuse
    cyc(0, '0, '0, 1, 32'h0050_0000, hX, "R4");
    for (int i = 1; i <= 4; i++) cyc(0, '0, '0, 1, 32'h0050_0000 + 32'(i * 16), hX, "R4");
    cyc(0, '0, '0, 1, 32'h0050_0000, hX, "R4");
    cyc(1, 32'h0050_0000, hX, 0, '0, '0, "R4");  // still not promoted

    // R6: fill and wrap tag store, evicting A (slot 0) but keeping B
    for (int i = 0; i < CAMD - 1; i++) insert2(32'h0100_0000 + 32'(i * 4), hX ^ 96'(i));
    cyc(1, pA, hA, 0, '0, '0, "R3");            // filter bits set, PC evicted
    idle(1, "R3");
    cyc(1, pB, hB, 0, '0, '0, "R6");            // B survives
    idle(7, "R6");
    insert2(pB, hA);                            // resident PC: pointer unmoved
    cyc(1, pB, hA, 0, '0, '0, "R6");
    idle(7, "R6");

    // random traffic over a small pool
    for (int i = 0; i < 4; i++) pool_h[i] = {$urandom, $urandom, $urandom};
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] rp, ep;
      rp = 32'h0200_0000 + 32'($urandom_range(0, 5) * 4);
      ep = 32'h0200_0000 + 32'($urandom_range(0, 5) * 4);
      cyc($urandom_range(0, 2) != 0, rp, pool_h[$urandom_range(0, 3)],
          $urandom_range(0, 3) == 0, ep, pool_h[$urandom_range(0, 3)], "R1");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule